// File: doc/BRIEF.md
# Two-Channel Event Status and Interrupt Controller

This block collects single-cycle event pulses from two command channel engines and keeps them as sticky status bits. Each channel reports five kinds of event: command finished, receive overflow, transmit starvation, poll expiry and bad control word. Each channel's five bits sit at the bottom of its own byte lane of a 32-bit status word. Channel c, event k appears at bit c*8+k. The event order within a lane is command finished (k=0), receive overflow (1), transmit starvation (2), poll expiry (3) and bad control word (4).

Software sees three 32-bit words through a register port:
- a raw status word at offset 0x08;
- a read-only masked view at offset 0x0C;
- an enable mask at offset 0x10.

Software acknowledges events by writing ones to the raw status word. A single interrupt line goes high whenever any enabled status bit is set.

The register port uses a valid/ready request channel and a valid/ready response channel. A request is taken on a cycle with `cmd_valid` and `cmd_ready` both high. A write completes with no response. A read produces one response that stays on `rsp_rdata` with `rsp_valid` high until `rsp_ready` is seen. While a response waits, `cmd_ready` is low, so a master that stalls the response also stalls further requests.

Top module: `evt_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_i[c*5+k]` sets raw status bit c*8+k at the clock edge where it is sampled. The bit stays set until it is cleared.
- R2: Writing offset 0x08 clears every raw status bit whose write-data bit is one. Raw status bits whose write-data bit is zero keep their value.
- R3: When an event and a clear hit the same raw bit in the same cycle, the bit ends up set.
- R4: The mask word at offset 0x10 is written and read back in full for the implemented positions (bits c*8+0..4). All other bit positions read zero.
- R5: A read of offset 0x0C returns raw status AND mask. Writes to 0x0C change nothing.
- R6: `irq` is high exactly when some raw status bit and its mask bit are both one.
- R7: Writing zero to the mask word drops `irq` and leaves raw status unchanged.
- R8: Writing 0xFF001F1F to offset 0x08 clears every raw status bit.
- R9: A read is answered in the cycle after it is accepted. `rsp_valid` and `rsp_rdata` hold steady until `rsp_ready` is high. `cmd_ready` is low while a response waits on a low `rsp_ready`.
- R10: After reset, raw status and mask are zero, `irq` is low and no response is pending.
- R11: A read of any other offset returns zero. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CH*EVT_BITS (10) | Event pulses; channel c event k on bit c*5+k |
| cmd_valid | input | 1 | Register request valid |
| cmd_ready | output | 1 | Register request accepted this cycle if valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W (8) | Byte offset of the register |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Master takes read data |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, high while any enabled status bit is set |

## Verification
The hardest case to reach from the ports is an event and a write-one-to-clear landing on the same bit in the same clock. The bench holds an event pulse and a clear write to offset 0x08 in one and the same cycle, then reads the bit back. A second hard case is a response stalled under back-pressure. The bench lowers `rsp_ready` before a read and samples `cmd_ready` and the held data over several cycles. It then injects an event during the stall, which must not alter the data already captured.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned OFS_RAW     = 'h08;
  localparam int unsigned OFS_MASKED  = 'h0C;
  localparam int unsigned OFS_ENABLE  = 'h10;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_ENABLE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_chan_status.sv
module evt_chan_status #(
  parameter int unsigned EVT_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EVT_BITS-1:0] evt,
  input  logic                clr_we,
  input  logic [EVT_BITS-1:0] clr_bits,
  input  logic                en_we,
  input  logic [EVT_BITS-1:0] en_bits,
  output logic [EVT_BITS-1:0] raw,
  output logic [EVT_BITS-1:0] en,
  output logic                any_hit
);
  logic [EVT_BITS-1:0] clr_eff;
  logic [EVT_BITS-1:0] raw_next;

  // Clear first, then OR in events so an event beats a clear.
  assign clr_eff  = clr_we ? clr_bits : '0;
  assign raw_next = (raw & ~clr_eff) | evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw <= '0;
      en  <= '0;
    end else begin
      raw <= raw_next;
      if (en_we) en <= en_bits;
    end
  end

  assign any_hit = |(raw & en);
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic [WORD_W-1:0] raw_word,
  input  logic [WORD_W-1:0] masked_word,
  input  logic [WORD_W-1:0] enable_word,
  output logic              raw_clr_we,
  output logic              enable_we
);
  reg_sel_e            sel;
  logic                take;
  logic [WORD_W-1:0]   rd_mux;

  always_comb begin
    if (cmd_addr == ADDR_W'(OFS_RAW))         sel = SEL_RAW;
    else if (cmd_addr == ADDR_W'(OFS_MASKED)) sel = SEL_MASKED;
    else if (cmd_addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
    else                                      sel = SEL_NONE;
  end

  assign cmd_ready  = !rsp_valid || rsp_ready;
  assign take       = cmd_valid && cmd_ready;
  assign raw_clr_we = take && cmd_write && (sel == SEL_RAW);
  assign enable_we  = take && cmd_write && (sel == SEL_ENABLE);

  always_comb begin
    unique case (sel)
      SEL_RAW:    rd_mux = raw_word;
      SEL_MASKED: rd_mux = masked_word;
      SEL_ENABLE: rd_mux = enable_word;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take && !cmd_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned EVT_BITS  = 5,
  parameter int unsigned CH_STRIDE = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH*EVT_BITS-1:0] evt_i,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_write,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [WORD_W-1:0]          cmd_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [WORD_W-1:0]          rsp_rdata,
  output logic                       irq
);
  localparam int unsigned VEC_W = NUM_CH * EVT_BITS;

  logic [VEC_W-1:0]  raw_vec;
  logic [VEC_W-1:0]  en_vec;
  logic [NUM_CH-1:0] ch_hit;
  logic [WORD_W-1:0] raw_word;
  logic [WORD_W-1:0] enable_word;
  logic [WORD_W-1:0] masked_word;
  logic              raw_clr_we;
  logic              enable_we;
  logic              wdata_unused;

  assign wdata_unused = ^cmd_wdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evt_chan_status #(.EVT_BITS(EVT_BITS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i[c*EVT_BITS +: EVT_BITS]),
      .clr_we   (raw_clr_we),
      .clr_bits (cmd_wdata[c*CH_STRIDE +: EVT_BITS]),
      .en_we    (enable_we),
      .en_bits  (cmd_wdata[c*CH_STRIDE +: EVT_BITS]),
      .raw      (raw_vec[c*EVT_BITS +: EVT_BITS]),
      .en       (en_vec[c*EVT_BITS +: EVT_BITS]),
      .any_hit  (ch_hit[c])
    );
  end

  always_comb begin
    raw_word    = '0;
    enable_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      raw_word[c*CH_STRIDE +: EVT_BITS]    = raw_vec[c*EVT_BITS +: EVT_BITS];
      enable_word[c*CH_STRIDE +: EVT_BITS] = en_vec[c*EVT_BITS +: EVT_BITS];
    end
  end
  assign masked_word = raw_word & enable_word;

  assign irq = |ch_hit;

  evt_reg_port #(.ADDR_W(ADDR_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_write   (cmd_write),
    .cmd_addr    (cmd_addr),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_rdata   (rsp_rdata),
    .raw_word    (raw_word),
    .masked_word (masked_word),
    .enable_word (enable_word),
    .raw_clr_we  (raw_clr_we),
    .enable_we   (enable_we)
  );
endmodule

// File: rtl/evt_irq_ctrl_sva.sv
module evt_irq_ctrl_sva #(
  parameter int unsigned VEC_W  = 10,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VEC_W-1:0]  evt_i,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              irq,
  input logic [VEC_W-1:0]  raw_vec,
  input logic [VEC_W-1:0]  en_vec
);
  logic clr_write;
  assign clr_write = cmd_valid && cmd_ready && cmd_write && (cmd_addr == ADDR_W'(8));

  // R1 and R3: a pulsed event is set after the edge, even against a clear
  assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_vec & $past(evt_i)) == $past(evt_i)));

  // R2 and R7: without a clear write, no raw bit falls
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_write |=> ((raw_vec & $past(raw_vec)) == $past(raw_vec)));

  // R6: nothing enabled means no interrupt
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> !irq);

  // R9: a stalled response holds its data
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R9: no request accepted behind a stalled response
  assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_sva #(
  .VEC_W  (NUM_CH*EVT_BITS),
  .ADDR_W (ADDR_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_write (cmd_write),
  .cmd_addr  (cmd_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .raw_vec   (raw_vec),
  .en_vec    (en_vec)
);

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;
  localparam int NCH = 2;
  localparam int EB  = 5;
  localparam int VW  = NCH*EB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] evt_i = '0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [7:0]    cmd_addr = '0;
  logic [31:0]   cmd_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_rdata;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] raw_m = '0;
  logic [31:0] en_m  = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  evt_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  function automatic logic [31:0] spread(input logic [VW-1:0] v);
    logic [31:0] w = '0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < EB; k++) w[c*8+k] = v[c*EB+k];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: sample just after the falling edge, before the handshake edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R9 unexpected response", 32'h1, 32'h0);
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    if (a == 8'h08)      e = raw_m;
    else if (a == 8'h0C) e = raw_m & en_m;
    else if (a == 8'h10) e = en_m;
    else                 e = '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cmd_valid = 1; cmd_write = 0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // Write, optionally with a simultaneous event vector
  task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [VW-1:0] ev);
    cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d; evt_i = ev;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0; evt_i = '0;
    if (a == 8'h08) raw_m = raw_m & ~(d & 32'h1F1F);
    if (a == 8'h10) en_m  = d & 32'h1F1F;
    raw_m = raw_m | spread(ev);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_evt(a, d, '0);
  endtask

  task automatic pulse(input logic [VW-1:0] ev);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
    raw_m = raw_m | spread(ev);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq", {31'b0, irq}, 32'h0);
    check("R10 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rd(8'h08, "R10 raw");
    rd(8'h10, "R10 mask");
    rd(8'h0C, "R10 masked");
    drain();

    // R1 events set sticky bits at stride positions
    pulse(10'b00_0000_0001);      // ch0 command finished -> bit 0
    pulse(10'b00_1000_0000);      // ch1 transmit starvation -> bit 10
    repeat (2) @(negedge clk);
    rd(8'h08, "R1 raw after events");
    check("R6 irq with mask zero", {31'b0, irq}, 32'h0);

    // R4 mask readback, R5 masked view, R6 irq
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, "R4 mask readback");
    rd(8'h0C, "R5 masked view");
    check("R6 irq enabled", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h0);
    rd(8'h08, "R5 write to masked ignored");

    // R7 disabling keeps raw
    wr(8'h10, 32'h0);
    check("R7 irq after mask zero", {31'b0, irq}, 32'h0);
    rd(8'h08, "R7 raw kept");

    // R2 write-one-to-clear
    wr(8'h08, 32'h0000_0400);
    rd(8'h08, "R2 clear bit 10");
    wr(8'h08, 32'h0);
    rd(8'h08, "R2 zero write no effect");

    // R3 event beats clear on same bit, and a clear of another bit still acts
    pulse(10'b10_0000_0000);      // ch1 bad control -> bit 12
    wr_evt(8'h08, 32'h0000_1001, 10'b00_0000_0001);
    rd(8'h08, "R3 event wins");

    // R8 clear-all pattern
    pulse('1);
    rd(8'h08, "R8 all set");
    wr(8'h08, 32'hFF00_1F1F);
    rd(8'h08, "R8 cleared");

    // R11 unmapped offsets
    wr(8'h10, 32'h0000_0013);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h10, "R11 mask after stray writes");
    rd(8'h04, "R11 unmapped read");
    rd(8'h14, "R11 unmapped read 0x14");

    // R6 single channel enable
    wr(8'h10, 32'h0000_1000);
    check("R6 irq idle", {31'b0, irq}, 32'h0);
    pulse(10'b10_0000_0000);
    check("R6 irq ch1 bad control", {31'b0, irq}, 32'h1);
    pulse(10'b00_0001_1111);
    wr(8'h08, 32'h0000_1000);
    check("R6 irq after clear", {31'b0, irq}, 32'h0);
    rd(8'h0C, "R6 masked view");
    drain();

    // R9 back-pressure
    rsp_ready = 0;
    rd(8'h08, "R9 held data");
    check("R9 rsp_valid stalled", {31'b0, rsp_valid}, 32'h1);
    check("R9 cmd_ready low", {31'b0, cmd_ready}, 32'h0);
    pulse(10'b01_0000_0000);
    repeat (2) @(negedge clk);
    check("R9 still valid", {31'b0, rsp_valid}, 32'h1);
    rsp_ready = 1;
    @(negedge clk);
    check("R9 released", {31'b0, rsp_valid}, 32'h0);
    check("R9 cmd_ready back", {31'b0, cmd_ready}, 32'h1);
    rd(8'h08, "R9 read after release");
    drain();

    check("scoreboard empty", 32'(exp_q.size()), 32'h0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule